// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block carries 18-bit words across two independent paths, one from side A to side B and one from side B to side A. Each path holds one storage word. That word can act as a transparent latch or as an edge-triggered register, and a per-path latch enable picks the behaviour on every cycle. In register mode, the word is loaded when the path strobe rises. An active-low clock enable can block that load. Each path also has an active-low output enable. The enable decides only whether the output bus is marked as driven. High impedance is modelled as a data bus plus a drive flag.

All logic runs on one system clock `clk` with a synchronous active-high reset `rst`. The path strobes are sampled as ordinary inputs, and a rising strobe is found by comparing each sample with the one taken on the previous cycle. The stored word and the drive flag are both registers. An input seen at a clock edge therefore shows up on the outputs one cycle later.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both stored words clear to zero and both drive flags go low.
- R2: When a path's latch enable is high at a clock edge, that path's output word equals the input word sampled at that edge (transparent mode, one cycle of latency).
- R3: When the latch enable is low and the path strobe does not rise (it stays high or stays low), the stored word does not change.
- R4: When the latch enable is low, the clock enable (active low) is 0 and the strobe is 1 at an edge where it was 0 at the previous edge, the input word is captured.
- R5: A rising strobe while the clock enable is 1 leaves the stored word unchanged.
- R6: The drive flag equals the inverse of the output enable sampled at the previous clock edge (output enable 1 = not driven).
- R7: The stored word keeps updating, in both transparent and register modes, while the output is not driven.
- R8: The latch enable has priority. While it is high, the word follows the input whatever the strobe and clock enable do.
- R9: After the latch enable falls, the last word loaded in transparent mode is kept until an enabled strobe rise or until the latch enable goes high again.
- R10: The B-to-A path behaves like the A-to-B path using its own controls, and neither path disturbs the other.
- R11: The strobe history resets to high, so a strobe that is already high when reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Side A word entering the A-to-B path |
| b_out | output | 18 | Side B word from the A-to-B path |
| b_drive | output | 1 | Side B is driven when high |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_strobe | input | 1 | A-to-B load strobe, acts on its rising edge |
| ab_cken_n | input | 1 | A-to-B clock enable, active low |
| b_in | input | 18 | Side B word entering the B-to-A path |
| a_out | output | 18 | Side A word from the B-to-A path |
| a_drive | output | 1 | Side A is driven when high |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (high = transparent) |
| ba_strobe | input | 1 | B-to-A load strobe, acts on its rising edge |
| ba_cken_n | input | 1 | B-to-A clock enable, active low |

## Verification
The assertions assume that all control and data inputs are synchronous to `clk` and stable around its rising edge. They also assume that a strobe edge lasts at least one clock period, so that each level is sampled at least once. The bench changes every input only on the falling edge of `clk` and holds each strobe level for at least one full period. It checks the outputs on the following falling edge, after exactly one rising edge has passed.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned NUM_PATHS = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic strobe;
    logic cken_n;
  } path_ctl_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;

  assert_rise_needs_low_history_R11: assert property (@(posedge clk) disable iff (rst)
    (!rst && rise) |=> !rise);
endmodule

// File: rtl/store_cell.sv
module store_cell #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         rise,
  input  logic         cken_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic load;
  assign load = le | (rise & ~cken_n);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == '0);
  assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && le) |=> q == $past(d));
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !le && rise && !cken_n) |=> q == $past(d));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !le && !rise) |=> $stable(q));
  assert_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !le && cken_n) |=> $stable(q));
endmodule

// File: rtl/drive_stage.sv
module drive_stage (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic drive
);
  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~oe_n;
  end

  assert_drive_on_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && !oe_n) |=> drive);
  assert_drive_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && oe_n) |=> !drive);
endmodule

// File: rtl/xfer_path.sv
module xfer_path
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  path_ctl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic rise;

  strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctl.strobe),
    .rise   (rise)
  );

  store_cell #(.W(W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .le     (ctl.le),
    .rise   (rise),
    .cken_n (ctl.cken_n),
    .d      (din),
    .q      (dout)
  );

  drive_stage u_drive (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (ctl.oe_n),
    .drive (drive)
  );
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_strobe,
  input  logic         ab_cken_n,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_strobe,
  input  logic         ba_cken_n
);
  path_ctl_t        ctl   [NUM_PATHS];
  logic [W-1:0]     din   [NUM_PATHS];
  logic [W-1:0]     dout  [NUM_PATHS];
  logic             drv   [NUM_PATHS];

  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, strobe: ab_strobe, cken_n: ab_cken_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, strobe: ba_strobe, cken_n: ba_cken_n};
  assign din[0] = a_in;
  assign din[1] = b_in;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xfer_path #(.W(W)) u_path (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl[p]),
      .din   (din[p]),
      .dout  (dout[p]),
      .drive (drv[p])
    );
  end

  assign b_out   = dout[0];
  assign b_drive = drv[0];
  assign a_out   = dout[1];
  assign a_drive = drv[1];

  // R10: a quiet B-to-A path keeps its word while A-to-B is active
  assert_paths_independent_R10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ba_le && (ba_cken_n || !ba_strobe)) |=> $stable(a_out));
endmodule

// File: tb/bus_xcvr_test.sv
module bus_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, b_out, a_out;
  logic b_drive, a_drive;
  logic ab_oe_n, ab_le, ab_strobe, ab_cken_n;
  logic ba_oe_n, ba_le, ba_strobe, ba_cken_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_xcvr #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_cken_n(ab_cken_n),
    .b_in(b_in), .a_out(a_out), .a_drive(a_drive),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_cken_n(ba_cken_n)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ab_oe_n = 1; ab_le = 0; ab_strobe = 0; ab_cken_n = 0;
    ba_oe_n = 1; ba_le = 0; ba_strobe = 0; ba_cken_n = 0;
    a_in = '0; b_in = '0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    idle(); ab_le = 1; a_in = 18'h2AAAA; tick();
    ab_le = 0; ab_oe_n = 0; tick();
    do_reset();
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 b_drive", {17'b0, b_drive}, 18'h0);
    chk("R1 a_drive", {17'b0, a_drive}, 18'h0);
  endtask

  task automatic t_transparent();
    ab_le = 1; a_in = 18'h12345; tick();
    chk("R2 follow1", b_out, 18'h12345);
    a_in = 18'h3FFFF; tick();
    chk("R2 follow2", b_out, 18'h3FFFF);
    ab_le = 0; a_in = 18'h00001; tick();
    chk("R9 kept after le fall", b_out, 18'h3FFFF);
    a_in = 18'h0F0F0; tick(); tick();
    chk("R3 hold strobe low", b_out, 18'h3FFFF);
  endtask

  task automatic t_capture();
    a_in = 18'h1BEEF; ab_strobe = 1; ab_cken_n = 0; tick();
    chk("R4 capture", b_out, 18'h1BEEF);
    a_in = 18'h00777; tick();
    chk("R3 hold strobe high", b_out, 18'h1BEEF);
    ab_strobe = 0; tick();
    chk("R3 hold on fall", b_out, 18'h1BEEF);
    ab_cken_n = 1; ab_strobe = 1; tick();
    chk("R5 gated", b_out, 18'h1BEEF);
    ab_strobe = 0; tick();
    ab_cken_n = 0; ab_strobe = 1; a_in = 18'h20002; tick();
    chk("R4 capture again", b_out, 18'h20002);
    ab_strobe = 0; tick();
  endtask

  task automatic t_priority();
    ab_le = 1; ab_cken_n = 1; ab_strobe = 1; a_in = 18'h0ABCD; tick();
    chk("R8 le over gated strobe", b_out, 18'h0ABCD);
    ab_cken_n = 0; ab_strobe = 0; a_in = 18'h15555; tick();
    chk("R8 le follows", b_out, 18'h15555);
    ab_le = 0; tick();
    a_in = 18'h00000; tick();
    chk("R9 kept", b_out, 18'h15555);
  endtask

  task automatic t_tristate();
    ab_oe_n = 1; tick();
    chk("R6 undriven", {17'b0, b_drive}, 18'h0);
    ab_le = 1; a_in = 18'h07E07; tick();
    chk("R7 latch updates while undriven", b_out, 18'h07E07);
    ab_le = 0; ab_strobe = 1; a_in = 18'h30303; tick();
    chk("R7 register updates while undriven", b_out, 18'h30303);
    ab_strobe = 0; ab_oe_n = 0; tick();
    chk("R6 driven", {17'b0, b_drive}, 18'h1);
    chk("R7 word after enable", b_out, 18'h30303);
  endtask

  task automatic t_reverse();
    ba_le = 1; b_in = 18'h2468A; tick();
    chk("R10 ba transparent", a_out, 18'h2468A);
    chk("R10 ab untouched", b_out, 18'h30303);
    ba_le = 0; ba_oe_n = 0; b_in = 18'h11111; tick();
    chk("R10 ba hold", a_out, 18'h2468A);
    chk("R10 ba drive", {17'b0, a_drive}, 18'h1);
    ba_strobe = 1; tick();
    chk("R10 ba capture", a_out, 18'h11111);
    ba_strobe = 0; ab_le = 1; a_in = 18'h3C3C3; tick();
    chk("R10 ba kept while ab moves", a_out, 18'h11111);
    ab_le = 0; tick();
  endtask

  task automatic t_strobe_high_at_reset();
    idle(); ab_strobe = 1; a_in = 18'h1F00F;
    do_reset(); tick();
    chk("R11 no edge after reset", b_out, '0);
    ab_strobe = 0; tick();
    ab_strobe = 1; tick();
    chk("R11 later edge captures", b_out, 18'h1F00F);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    tick();
    t_reset();
    t_transparent();
    t_capture();
    t_priority();
    t_tristate();
    t_reverse();
    t_strobe_high_at_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule